// File: doc/BRIEF.md
# Phase-Aligned Synchronous Serial Transmitter

This block is the peripheral end of a clocked serial link. It drives both the serial clock and the serial data toward a host, one byte per frame. A frame is a low start bit, eight data bits least significant first, one high stop bit, and a second stop bit when configured. The length of each bit is set by the matching serial clock pulse. Data changes on the falling clock edge, so it is steady at the rising edge where the host samples it. Ordinary bits last a programmable number of fast-clock cycles, never fewer than three. The start bit is programmed separately and never lasts fewer than six cycles.

The host returns a slow clock that may carry glitches. The block synchronises and filters this clock, then times each accepted rising edge against its own most recent falling edge. That delay is shown on `phase_out`. When a delay falls inside a configurable forbidden window, the next start bit is made one cycle longer or one cycle shorter, whichever moves the phase toward the nearer edge of the window. Corrections are only ever applied to the start bit, so no ordinary bit is ever shortened.

Top module: `sync_phase_tx`

## Requirements
- R1: During and after reset, and whenever the block is idle, `sclk_out` and `sdata_out` are high and `in_ready` is high. `phase_out` resets to 0.
- R2: A frame is start bit 0, then `in_data[0]` to `in_data[7]`, then stop bit 1, then a second stop bit 1 only when `cfg_stop2` is 1. `sdata_out` changes only when `sclk_out` falls. The start bit begins in the cycle after the byte is accepted.
- R3: Every bit other than the start bit lasts L = max(`cfg_bit_len`, 3) cycles. In each bit, `sclk_out` is low for floor(L/2) cycles and then high.
- R4: The start bit lasts max(`cfg_start_len` + a, 6) cycles. The correction a is +1, -1 or 0 as given by R7.
- R5: A timer restarts on each falling edge of `sclk_out` and saturates at 255. Take the cycle in which `sclk_out` falls. If the reference rises D cycles later and stays high for at least N cycles, `phase_out` becomes D + N + 2. N is max(`cfg_filt_len`, 1).
- R6: A reference level change is accepted only after N consecutive synchronised samples at the new level. A high pulse shorter than N cycles leaves `phase_out` unchanged.
- R7: Let t be a captured delay with `cfg_win_lo` <= t <= `cfg_win_hi`. Then a = +1 if t - lo <= hi - t, otherwise a = -1. A capture outside the window sets a = 0. The correction is used by the next frame only, and later frames use a = 0.
- R8: Suppose a capture lands in the same cycle that a byte is accepted. The frame starting in that cycle uses the correction pending before the capture. The new capture applies to the following frame.
- R9: A byte is accepted on a cycle where `in_valid` and `in_ready` are both high. `in_ready` stays low until the last stop bit ends. Bit lengths and `cfg_stop2` are sampled at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one cycle is one timing unit |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte available |
| in_ready | output | 1 | Block idle, can accept a byte |
| in_data | input | 8 | Byte to send |
| cfg_bit_len | input | 8 | Ordinary bit length in cycles |
| cfg_start_len | input | 8 | Start bit length in cycles before correction |
| cfg_stop2 | input | 1 | Add a second stop bit |
| cfg_filt_len | input | 4 | Samples needed to accept a reference level |
| cfg_win_lo | input | 8 | Forbidden window lower delay, inclusive |
| cfg_win_hi | input | 8 | Forbidden window upper delay, inclusive |
| ref_clk_in | input | 1 | Clock returned by the host, asynchronous |
| sclk_out | output | 1 | Generated serial clock |
| sdata_out | output | 1 | Serial data |
| phase_out | output | 8 | Last measured delay in cycles |

## Verification
Two functions can meet in one cycle: a phase capture and the consumption of the pending correction when a byte is accepted. The bench leaves the block idle until the timer saturates. It then raises the reference exactly N + 2 cycles before asserting `in_valid`, so the filtered rising edge is seen in the acceptance cycle. With a window covering every delay, the saturated delay requests a shortening. The frame that starts must keep its programmed start length, and the following frame must be one cycle shorter. A design that lets the consumption clear the new request shows up as an unshortened second frame.

// File: rtl/sync_phase_tx_pkg.sv
// Shared types and limits for the phase-aligned synchronous transmitter.
package sync_phase_tx_pkg;
    // Shortest ordinary bit, in fast-clock cycles
    localparam int MIN_BIT   = 3;
    // Shortest start bit, in fast-clock cycles
    localparam int MIN_START = 6;

    // Pending start-bit correction
    typedef enum logic [1:0] {
        ADJ_NONE  = 2'd0,
        ADJ_LONG  = 2'd1,
        ADJ_SHORT = 2'd2
    } adj_t;
endpackage

// File: rtl/sync_ref_filter.sv
// Two-flop synchroniser followed by a persistence filter for the returned
// host clock. A new level is accepted only after it has been sampled on
// filt_len consecutive cycles (0 counts as 1). Assumes ref_raw is asynchronous.
module sync_ref_filter #(
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_raw,
    input  logic [FILT_W-1:0] filt_len,
    output logic              level
);
    logic              sync1, sync2;
    logic [FILT_W-1:0] run_cnt;
    logic [FILT_W-1:0] need;

    // Effective number of samples required
    always_comb need = (filt_len == '0) ? FILT_W'(1) : filt_len;

    // Bring the reference into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= ref_raw;
            sync2 <= sync1;
        end
    end

    // Count consecutive differing samples and switch level when enough are seen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level   <= 1'b0;
            run_cnt <= '0;
        end else if (sync2 == level) begin
            run_cnt <= '0;
        end else if (run_cnt == need - FILT_W'(1)) begin
            level   <= sync2;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + FILT_W'(1);
        end
    end
endmodule

// File: rtl/sync_phase_meter.sv
// Times the filtered reference rising edge against the last falling edge of
// the generated clock, and turns a delay inside the forbidden window into a
// start-bit correction request. A capture overrides consumption in the same cycle.
module sync_phase_meter
    import sync_phase_tx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             ref_lvl,
    input  logic [CNT_W-1:0] win_lo,
    input  logic [CNT_W-1:0] win_hi,
    input  logic             start_take,
    output logic [CNT_W-1:0] phase,
    output adj_t             adj_req
);
    logic             sclk_q, lvl_q;
    logic [CNT_W-1:0] timer;
    logic             rise, in_win;
    logic [CNT_W-1:0] to_lo, to_hi;

    // Edge detection and window distance
    always_comb begin
        rise   = ref_lvl && !lvl_q;
        in_win = (timer >= win_lo) && (timer <= win_hi);
        to_lo  = timer - win_lo;
        to_hi  = win_hi - timer;
    end

    // Saturating delay timer restarted at each generated falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
            lvl_q  <= 1'b0;
            timer  <= '0;
        end else begin
            sclk_q <= sclk;
            lvl_q  <= ref_lvl;
            if (sclk_q && !sclk)
                timer <= CNT_W'(1);
            else if (timer != '1)
                timer <= timer + CNT_W'(1);
        end
    end

    // Capture the delay and update the pending correction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= '0;
            adj_req <= ADJ_NONE;
        end else if (rise) begin
            phase <= timer;
            if (in_win)
                adj_req <= (to_lo <= to_hi) ? ADJ_LONG : ADJ_SHORT;
            else
                adj_req <= ADJ_NONE;
        end else if (start_take) begin
            adj_req <= ADJ_NONE;
        end
    end
endmodule

// File: rtl/sync_tx_engine.sv
// Frame sequencer: start bit, eight data bits LSB first, one or two stop
// bits. Each bit has its own length counter. The clock is low for the first
// half of a bit, and data changes only at bit boundaries. The start-bit length
// carries the pending correction; ordinary bits never fall below MIN_BIT.
module sync_tx_engine
    import sync_phase_tx_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic [LEN_W-1:0] cfg_bit_len,
    input  logic [LEN_W-1:0] cfg_start_len,
    input  logic             cfg_stop2,
    input  adj_t             adj_req,
    output logic             start_take,
    output logic             sclk,
    output logic             sdata
);
    localparam int CW = LEN_W + 1;

    logic          busy, stop2_q;
    logic [3:0]    bit_idx, last_idx;
    logic [CW-1:0] cnt, cur_len, norm_len;
    logic [10:0]   frame;
    logic [CW-1:0] base, adjd, start_len, bit_len_calc;

    // Effective start and ordinary bit lengths with their floors
    always_comb begin
        base = {1'b0, cfg_start_len};
        case (adj_req)
            ADJ_LONG:  adjd = base + CW'(1);
            ADJ_SHORT: adjd = (base == '0) ? '0 : base - CW'(1);
            default:   adjd = base;
        endcase
        start_len    = (adjd < CW'(MIN_START)) ? CW'(MIN_START) : adjd;
        bit_len_calc = ({1'b0, cfg_bit_len} < CW'(MIN_BIT)) ? CW'(MIN_BIT)
                                                            : {1'b0, cfg_bit_len};
    end

    // Handshake and line outputs
    always_comb begin
        in_ready   = !busy;
        start_take = in_valid && !busy;
        last_idx   = stop2_q ? 4'd10 : 4'd9;
        sclk       = !(busy && (cnt < (cur_len >> 1)));
        sdata      = busy ? frame[0] : 1'b1;
    end

    // Bit sequencing and length counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            stop2_q  <= 1'b0;
            bit_idx  <= '0;
            cnt      <= '0;
            cur_len  <= CW'(MIN_START);
            norm_len <= CW'(MIN_BIT);
            frame    <= '1;
        end else if (!busy) begin
            if (in_valid) begin
                busy     <= 1'b1;
                bit_idx  <= '0;
                cnt      <= '0;
                cur_len  <= start_len;
                norm_len <= bit_len_calc;
                stop2_q  <= cfg_stop2;
                frame    <= {2'b11, in_data, 1'b0};
            end
        end else if (cnt == cur_len - CW'(1)) begin
            if (bit_idx == last_idx) begin
                busy <= 1'b0;
            end else begin
                bit_idx <= bit_idx + 4'd1;
                cnt     <= '0;
                cur_len <= norm_len;
                frame   <= {1'b1, frame[10:1]};
            end
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/sync_phase_tx.sv
// Top level: transmitter engine, reference filter and phase meter.
// Assumes ref_clk_in is asynchronous and much slower than clk.
module sync_phase_tx
    import sync_phase_tx_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 8,
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic [LEN_W-1:0]  cfg_bit_len,
    input  logic [LEN_W-1:0]  cfg_start_len,
    input  logic              cfg_stop2,
    input  logic [FILT_W-1:0] cfg_filt_len,
    input  logic [CNT_W-1:0]  cfg_win_lo,
    input  logic [CNT_W-1:0]  cfg_win_hi,
    input  logic              ref_clk_in,
    output logic              sclk_out,
    output logic              sdata_out,
    output logic [CNT_W-1:0]  phase_out
);
    logic ref_lvl;
    logic start_take;
    adj_t adj_req;

    sync_ref_filter #(.FILT_W(FILT_W)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_raw  (ref_clk_in),
        .filt_len (cfg_filt_len),
        .level    (ref_lvl)
    );

    sync_phase_meter #(.CNT_W(CNT_W)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk_out),
        .ref_lvl    (ref_lvl),
        .win_lo     (cfg_win_lo),
        .win_hi     (cfg_win_hi),
        .start_take (start_take),
        .phase      (phase_out),
        .adj_req    (adj_req)
    );

    sync_tx_engine #(.LEN_W(LEN_W)) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_data       (in_data),
        .cfg_bit_len   (cfg_bit_len),
        .cfg_start_len (cfg_start_len),
        .cfg_stop2     (cfg_stop2),
        .adj_req       (adj_req),
        .start_take    (start_take),
        .sclk          (sclk_out),
        .sdata         (sdata_out)
    );
endmodule

// File: rtl/sync_phase_tx_chk.sv
// Checker for the port-level protocol of sync_phase_tx, attached by bind.
module sync_phase_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic sclk_out,
    input logic sdata_out
);
    // R1: idle lines rest high
    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (sclk_out && sdata_out));

    // R2: leaving idle starts a low start bit with the clock low
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> (!sdata_out && !sclk_out));

    // R2: data moves only together with a falling clock
    assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(sclk_out) |-> $stable(sdata_out));

    // R3: every high clock phase lasts at least two cycles
    assert_high_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_out) |=> sclk_out);

    // R9: an accepted byte makes the block busy
    assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
endmodule

bind sync_phase_tx sync_phase_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .sclk_out  (sclk_out),
    .sdata_out (sdata_out)
);

// File: tb/test_sync_phase_tx.sv
`timescale 1ns/1ps
// Bench for sync_phase_tx: frame sweep, phase capture, filtering, corrections.
module test_sync_phase_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic [7:0] cfg_bit_len = 8'd3;
    logic [7:0] cfg_start_len = 8'd6;
    logic       cfg_stop2 = 1'b0;
    logic [3:0] cfg_filt_len = 4'd3;
    logic [7:0] cfg_win_lo = 8'd200;
    logic [7:0] cfg_win_hi = 8'd100;
    logic       ref_clk_in = 1'b0;
    logic       sclk_out, sdata_out;
    logic [7:0] phase_out;

    int checks = 0;
    int errors = 0;
    int lens [16];
    logic vals [16];

    always #10 clk = ~clk;

    sync_phase_tx i_sync_phase_tx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .cfg_bit_len(cfg_bit_len), .cfg_start_len(cfg_start_len),
        .cfg_stop2(cfg_stop2), .cfg_filt_len(cfg_filt_len), .cfg_win_lo(cfg_win_lo),
        .cfg_win_hi(cfg_win_hi), .ref_clk_in(ref_clk_in), .sclk_out(sclk_out),
        .sdata_out(sdata_out), .phase_out(phase_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sends one byte starting at a negedge and decodes the line until idle.
    // inj_d >= 0 injects a reference pulse inj_d cycles after the second fall.
    task automatic run_frame(input logic [7:0] b, input int exp_start, input int exp_bit,
                             input int inj_d, input int inj_w);
        int   cyc = 0, last = 0, nfall = 0, k = 0, stage = 0, guard = 0;
        bit   armed = 0, prev_s = 1, s;
        logic [7:0] got;
        in_data  = b;
        in_valid = 1'b1;
        forever begin
            if (stage == 0 && in_ready) stage = 1;
            @(negedge clk);
            cyc++;
            guard++;
            if (guard > 20000) begin
                chk("R9 frame end", 0, 1);
                break;
            end
            if (stage == 1) begin
                in_valid = 1'b0;
                stage = 2;
            end
            s = sclk_out;
            if (stage == 2) begin
                if (prev_s && !s) begin
                    if (nfall > 0) lens[nfall-1] = cyc - last;
                    else chk("R9 busy after accept", int'(in_ready), 0);
                    last = cyc;
                    nfall++;
                    if (inj_d >= 0 && nfall == 2) begin
                        armed = 1;
                        k = 0;
                    end
                end
                if (!prev_s && s && nfall > 0) vals[nfall-1] = sdata_out;
                if (armed) begin
                    if (k == inj_d) ref_clk_in = 1'b1;
                    if (k == inj_d + inj_w) begin
                        ref_clk_in = 1'b0;
                        armed = 0;
                    end
                    k++;
                end
                if (in_ready && nfall > 0) begin
                    lens[nfall-1] = cyc - last;
                    break;
                end
            end
            prev_s = s;
        end
        // R2: bit count, framing and data order
        chk("R2 bit count", nfall, cfg_stop2 ? 11 : 10);
        chk("R2 start value", int'(vals[0]), 0);
        for (int i = 0; i < 8; i++) got[i] = vals[i+1];
        chk("R2 data byte LSB first", int'(got), int'(b));
        chk("R2 stop value", int'(vals[9]), 1);
        if (cfg_stop2) chk("R2 second stop value", int'(vals[10]), 1);
        // R4: start length; R3: every ordinary bit length
        chk("R4 start length", lens[0], exp_start);
        for (int i = 1; i < nfall; i++)
            if (lens[i] != exp_bit) chk("R3 bit length", lens[i], exp_bit);
        checks++;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int blv, st;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sclk in reset", int'(sclk_out), 1);
        chk("R1 sdata in reset", int'(sdata_out), 1);
        chk("R1 ready in reset", int'(in_ready), 1);
        chk("R1 phase in reset", int'(phase_out), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle lines", int'(sclk_out && sdata_out && in_ready), 1);

        // R2 R3 R4: sweep of bit length, start length, stop count and data
        for (int bl = 0; bl < 7; bl++) begin
            for (int s2 = 0; s2 < 2; s2++) begin
                blv = (bl < 5) ? bl + 1 : bl * 2;
                st  = (bl % 3 == 0) ? 2 : ((bl % 3 == 1) ? 6 : 9);
                cfg_bit_len   = 8'(blv);
                cfg_start_len = 8'(st);
                cfg_stop2     = s2[0];
                run_frame((bl == 0) ? (s2 == 0 ? 8'h00 : 8'hFF) : 8'(8'h3C * bl + 8'h5A * s2 + 1),
                          (st < 6) ? 6 : st, (blv < 3) ? 3 : blv, -1, 0);
            end
        end

        // R5: phase capture with N = 3
        cfg_bit_len = 8'd40; cfg_start_len = 8'd10; cfg_stop2 = 1'b0;
        cfg_filt_len = 4'd3;
        run_frame(8'h81, 10, 40, 5, 3);
        chk("R5 delay N=3", int'(phase_out), 5 + 3 + 2);
        // R5: filter length 0 treated as 1
        cfg_filt_len = 4'd0;
        run_frame(8'h42, 10, 40, 9, 4);
        chk("R5 delay N=1", int'(phase_out), 9 + 1 + 2);
        // R6: short pulse rejected
        cfg_filt_len = 4'd3;
        run_frame(8'h24, 10, 40, 4, 2);
        chk("R6 glitch ignored", int'(phase_out), 12);
        run_frame(8'h18, 10, 40, -1, 0);

        // R7: delay 10 near low edge of [8,14] -> lengthen once
        cfg_win_lo = 8'd8; cfg_win_hi = 8'd14;
        run_frame(8'hC3, 10, 40, 5, 3);
        run_frame(8'h3C, 11, 40, -1, 0);
        run_frame(8'h5A, 10, 40, -1, 0);
        // R7: delay 10 near high edge of [6,12] -> shorten once
        cfg_win_lo = 8'd6; cfg_win_hi = 8'd12;
        run_frame(8'hA5, 10, 40, 5, 3);
        run_frame(8'h96, 9, 40, -1, 0);
        run_frame(8'h69, 10, 40, -1, 0);
        // R7: delay outside [20,30] -> no correction
        cfg_win_lo = 8'd20; cfg_win_hi = 8'd30;
        run_frame(8'h0F, 10, 40, 5, 3);
        run_frame(8'hF0, 10, 40, -1, 0);
        // R4: start floor of 6 holds under a shortening
        cfg_start_len = 8'd6; cfg_win_lo = 8'd6; cfg_win_hi = 8'd12;
        run_frame(8'h11, 6, 40, 5, 3);
        run_frame(8'h22, 6, 40, -1, 0);

        // R8: capture in the acceptance cycle goes to the following frame
        cfg_start_len = 8'd10; cfg_win_lo = 8'd0; cfg_win_hi = 8'd255;
        repeat (300) @(negedge clk);
        ref_clk_in = 1'b1;
        repeat (5) @(negedge clk);
        run_frame(8'h77, 10, 40, -1, 0);
        chk("R5 saturated delay", int'(phase_out), 255);
        run_frame(8'h88, 9, 40, -1, 0);
        ref_clk_in = 1'b0;
        cfg_win_lo = 8'd200; cfg_win_hi = 8'd100;
        repeat (10) @(negedge clk);
        run_frame(8'h99, 10, 40, -1, 0);
        chk("R1 idle after frames", int'(sclk_out && sdata_out && in_ready), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule